// File: doc/BRIEF.md
# Addressable Asynchronous Serial Port with Even Parity

This block is the serial front end of a measurement peripheral. It moves bytes over a two-wire asynchronous line in 11-bit frames: a low start bit, eight data bits with the least significant bit first, an even parity bit and a high stop bit. The bit rate comes from the system clock: a sample tick is produced every 512, 128, 16 or 8 clocks, and one bit lasts sixteen ticks. The receiver oversamples the line, takes each bit at its centre and checks parity and the stop bit. The transmitter sends one byte per load request and reports busy while it shifts.

Two access modes are offered. In the plain mode, an active-low chip select gates both directions. In the addressed mode, up to 32 ports share one line pair. Each port compares incoming address bytes with its own 5-bit hardwired address. A match selects the port and a different address deselects it. The selection persists between address bytes. Address bytes are consumed by the port and never handed on. Data bytes reach the command layer, and transmission is allowed, only while the port is selected. The command layer above reads the received-byte strobe, the byte itself and a parity flag. It can use that flag when it later builds a status reply.

Top module: `addr_uart`

## Requirements
- R1: A transmitted frame on `txd_o` is one low start bit, the eight bits of `tx_data_i` with bit 0 first, a parity bit equal to the XOR of the eight data bits (even parity), and one high stop bit. Each bit lasts 16 sample ticks, and `tx_busy_o` falls once the stop bit has ended.
- R2: With `baud_sel_i` = 2'b00, 2'b10, 2'b01 and 2'b11, a sample tick lasts 512, 128, 16 and 8 clocks, so one bit lasts 8192, 2048, 256 and 128 clocks.
- R3: A received frame with a high stop bit that the port accepts gives exactly one single-cycle pulse on `rx_valid_o`, with the byte on `rx_data_o` in that cycle.
- R4: `parity_err_o` changes only when a byte is delivered. It becomes 1 if the received parity bit does not make the nine bits even, and 0 otherwise. It keeps that value until the next delivered byte.
- R5: A frame whose stop bit is sampled low is dropped: no `rx_valid_o` pulse.
- R6: A falling edge on `rxd_i` that is high again at the eighth tick (mid start bit) is ignored. A valid frame that follows is received normally.
- R7: In plain mode (`addr_mode_i`=0) with `cs_n_i` high, received bytes are not delivered and `tx_load_i` is ignored (`tx_busy_o` stays 0, `txd_o` stays high).
- R8: In addressed mode, a byte with bit 7 = 1 and bits 6:5 = 00 is an address byte carrying the target in bits 4:0. It is never delivered. Bytes of any other pattern are data.
- R9: An address byte whose bits 4:0 equal `dev_addr_i` selects the port. While selected, data bytes are delivered and `tx_load_i` is accepted whatever `cs_n_i` is. Before any match, data bytes are dropped and loads are ignored.
- R10: An address byte with a different address deselects the port. Later data bytes are dropped until a matching address byte arrives.
- R11: A `tx_load_i` pulse while `tx_busy_o` is high is ignored, and the frame in progress finishes unchanged.
- R12: After reset, `txd_o` is high, `tx_busy_o`, `rx_valid_o` and `parity_err_o` are 0, and the port is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| cs_n_i | input | 1 | Active-low chip select, plain mode only |
| dev_addr_i | input | 5 | Hardwired port address for addressed mode |
| addr_mode_i | input | 1 | 1 = addressed mode, 0 = plain mode |
| baud_sel_i | input | 2 | Sample-tick divisor select |
| tx_load_i | input | 1 | Request to send `tx_data_i` |
| tx_data_i | input | 8 | Byte to transmit |
| txd_o | output | 1 | Serial transmit line, idle high |
| tx_busy_o | output | 1 | Transmit frame in progress |
| rx_valid_o | output | 1 | One-cycle strobe for a delivered byte |
| rx_data_o | output | 8 | Delivered byte |
| parity_err_o | output | 1 | Parity result of the last delivered byte |

## Verification
The transmitter and the receiver run from separate tick counters, so a transmit bit boundary and a receive centre sample can land on the same clock edge while both share the enable decided by chip select. To provoke this, the bench issues a load and starts driving a receive frame in the same falling-edge slot, at the same rate. It then checks every transmitted bit at its centre and checks the received byte and its parity flag. A second collision is a load request issued in the middle of a frame. This is judged by the serial waveform, which must still carry the first byte bit for bit.

// File: rtl/addr_uart_pkg.sv
package addr_uart_pkg;

  localparam int OSR        = 16;
  localparam int OS_W       = $clog2(OSR);
  localparam int FRAME_BITS = 11;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_t;

  function automatic logic is_addr_byte(input logic [7:0] b);
    return b[7] & ~b[6] & ~b[5];
  endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_S0 = 512,
  parameter int DIV_S1 = 16,
  parameter int DIV_S2 = 128,
  parameter int DIV_S3 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int DIV_A   = (DIV_S0 > DIV_S1) ? DIV_S0 : DIV_S1;
  localparam int DIV_B   = (DIV_S2 > DIV_S3) ? DIV_S2 : DIV_S3;
  localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int CNT_W   = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (sel)
      2'd0:    lim = CNT_W'(DIV_S0);
      2'd1:    lim = CNT_W'(DIV_S1);
      2'd2:    lim = CNT_W'(DIV_S2);
      default: lim = CNT_W'(DIV_S3);
    endcase
  end

  assign tick = !restart && (cnt_q >= lim - 1'b1);

  always_comb begin
    if (restart || cnt_q >= lim - 1'b1) cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a period never outlives the selected divisor
  p_wrap_after_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= lim - 1'b1) |=> (cnt_q == '0));

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import addr_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] data,
  output logic       restart,
  output logic       busy,
  output logic       txd
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [OS_W-1:0]       os_q, os_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic                  busy_d;
  logic                  take;

  assign take    = load && !busy;
  assign restart = take;
  assign txd     = busy ? sh_q[0] : 1'b1;

  always_comb begin
    sh_d   = sh_q;
    os_d   = os_q;
    bit_d  = bit_q;
    busy_d = busy;
    if (take) begin
      sh_d   = {1'b1, ^data, data, 1'b0};
      os_d   = '0;
      bit_d  = '0;
      busy_d = 1'b1;
    end else if (busy && tick) begin
      os_d = os_q + 1'b1;
      if (os_q == OS_W'(OSR - 1)) begin
        sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
        bit_d = bit_q + 1'b1;
        if (bit_q == BIT_W'(FRAME_BITS - 1)) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      os_q  <= '0;
      bit_q <= '0;
      busy  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      os_q  <= os_d;
      bit_q <= bit_d;
      busy  <= busy_d;
    end
  end

  // R1: every frame opens with a low start bit
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  // R11: a load during a frame does not restart the bit counter
  p_no_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load && !tick) |=> $stable(bit_q));

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import addr_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick,
  output logic       restart,
  output logic       done,
  output logic [7:0] data,
  output logic       par_ok
);
  localparam logic [OS_W-1:0] MID = OS_W'(OSR / 2 - 1);

  rx_state_t        st_q, st_d;
  logic [2:0]       sync_q;
  logic [OS_W-1:0]  os_q, os_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [8:0]       sh_q, sh_d;
  logic             done_d;
  logic             line, fall;

  assign line    = sync_q[1];
  assign fall    = sync_q[2] && !sync_q[1];
  assign restart = (st_q == RX_IDLE) && fall;
  assign data    = sh_q[7:0];
  assign par_ok  = ~^sh_q;

  always_comb begin
    st_d   = st_q;
    os_d   = os_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    case (st_q)
      RX_IDLE: if (fall) begin
        st_d = RX_START;
        os_d = '0;
      end
      RX_START: if (tick) begin
        os_d = os_q + 1'b1;
        if (os_q == MID) begin
          st_d  = line ? RX_IDLE : RX_BITS;
          bit_d = '0;
        end
      end
      RX_BITS: if (tick) begin
        os_d = os_q + 1'b1;
        if (os_q == MID) begin
          if (bit_q < BIT_W'(9)) begin
            sh_d  = {line, sh_q[8:1]};
            bit_d = bit_q + 1'b1;
          end else begin
            st_d   = RX_IDLE;
            done_d = line;
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      st_q   <= RX_IDLE;
      os_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      done   <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], rxd};
      st_q   <= st_d;
      os_q   <= os_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      done   <= done_d;
    end
  end

  // R3: completion is a single-cycle event
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: a completed frame always leaves the receiver idle
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st_q == RX_IDLE));

endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
  import addr_uart_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [7:0]        frame_data,
  input  logic              frame_par_ok,
  input  logic              addr_mode,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              perr,
  output logic              tx_en
);
  logic sel_q, sel_d;
  logic addr_hit, deliver;

  assign addr_hit = frame_done && addr_mode && is_addr_byte(frame_data);
  assign deliver  = frame_done &&
                    (addr_mode ? (!is_addr_byte(frame_data) && sel_q) : !cs_n);
  assign tx_en    = addr_mode ? sel_q : !cs_n;

  always_comb begin
    sel_d = sel_q;
    if (addr_hit) sel_d = (frame_data[ADDR_W-1:0] == dev_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      perr     <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      rx_valid <= deliver;
      if (deliver) begin
        rx_data <= frame_data;
        perr    <= !frame_par_ok;
      end
    end
  end

  // R8: address bytes never reach the command layer
  p_addr_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> !rx_valid);

  // R10: a foreign address drops the selection
  p_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hit && frame_data[ADDR_W-1:0] != dev_addr) |=> !sel_q);

endmodule

// File: rtl/addr_uart.sv
module addr_uart #(
  parameter int DIV_S0 = 512,
  parameter int DIV_S1 = 16,
  parameter int DIV_S2 = 128,
  parameter int DIV_S3 = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              cs_n_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              addr_mode_i,
  input  logic [1:0]        baud_sel_i,
  input  logic              tx_load_i,
  input  logic [7:0]        tx_data_i,
  output logic              txd_o,
  output logic              tx_busy_o,
  output logic              rx_valid_o,
  output logic [7:0]        rx_data_o,
  output logic              parity_err_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tx_tick, tx_restart, rx_tick, rx_restart;
  logic       frame_done, frame_par_ok, tx_en;
  logic [7:0] frame_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  uart_baud_tick #(.DIV_S0(DIV_S0), .DIV_S1(DIV_S1), .DIV_S2(DIV_S2), .DIV_S3(DIV_S3))
    i_tx_tick (.clk(clk), .rst_n(rst_int_n), .restart(tx_restart),
               .sel(baud_sel_i), .tick(tx_tick));

  uart_baud_tick #(.DIV_S0(DIV_S0), .DIV_S1(DIV_S1), .DIV_S2(DIV_S2), .DIV_S3(DIV_S3))
    i_rx_tick (.clk(clk), .rst_n(rst_int_n), .restart(rx_restart),
               .sel(baud_sel_i), .tick(rx_tick));

  uart_tx_core i_tx (
    .clk(clk), .rst_n(rst_int_n), .tick(tx_tick),
    .load(tx_load_i && tx_en), .data(tx_data_i),
    .restart(tx_restart), .busy(tx_busy_o), .txd(txd_o));

  uart_rx_core i_rx (
    .clk(clk), .rst_n(rst_int_n), .rxd(rxd_i), .tick(rx_tick),
    .restart(rx_restart), .done(frame_done), .data(frame_data),
    .par_ok(frame_par_ok));

  uart_addr_filter #(.ADDR_W(ADDR_W)) i_filt (
    .clk(clk), .rst_n(rst_int_n), .frame_done(frame_done),
    .frame_data(frame_data), .frame_par_ok(frame_par_ok),
    .addr_mode(addr_mode_i), .cs_n(cs_n_i), .dev_addr(dev_addr_i),
    .rx_valid(rx_valid_o), .rx_data(rx_data_o), .perr(parity_err_o),
    .tx_en(tx_en));

  // R7: a frame only starts when the access gate was open
  p_tx_gated_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(tx_busy_o) |-> $past(tx_en && tx_load_i));

endmodule

// File: tb/test_addr_uart.sv
module test_addr_uart;
  localparam int DIVF = 8;
  localparam int BT   = 16 * DIVF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1, cs_n = 1'b0, amode = 1'b0, load = 1'b0;
  logic [4:0] dev = 5'h13;
  logic [1:0] bsel = 2'b11;
  logic [7:0] tdata = '0;
  logic       txd, busy, rvalid, perr;
  logic [7:0] rdata;

  int n_chk = 0, n_bad = 0, n_got = 0;
  logic [7:0] last_data;
  logic       last_perr;
  bit         finished = 0;

  always #10 clk = ~clk;

  addr_uart i_addr_uart (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .cs_n_i(cs_n), .dev_addr_i(dev),
    .addr_mode_i(amode), .baud_sel_i(bsel), .tx_load_i(load), .tx_data_i(tdata),
    .txd_o(txd), .tx_busy_o(busy), .rx_valid_o(rvalid), .rx_data_o(rdata),
    .parity_err_o(perr));

  always @(negedge clk) if (rvalid) begin
    n_got++;
    last_data = rdata;
    last_perr = perr;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    load = 1'b0; rxd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [10:0] f;
    f = {~bad_stop, (^d) ^ bad_par, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk) rxd = f[i];
      repeat (BT - 1) @(negedge clk);
    end
    @(negedge clk) rxd = 1'b1;
    repeat (BT) @(negedge clk);
  endtask

  task automatic tx_check(input logic [7:0] d, input bit poke, input string req);
    logic [10:0] f;
    f = {1'b1, ^d, d, 1'b0};
    @(negedge clk) begin tdata = d; load = 1'b1; end
    @(negedge clk) load = 1'b0;
    repeat (BT / 2) @(negedge clk);
    for (int i = 0; i < 11; i++) begin
      check(txd == f[i], req, txd, f[i]);
      if (i < 10) begin
        if (poke && i == 3) begin
          @(negedge clk) begin load = 1'b1; tdata = ~d; end
          @(negedge clk) load = 1'b0;
          repeat (BT - 2) @(negedge clk);
        end else repeat (BT) @(negedge clk);
      end
    end
    repeat (BT / 2 + 2) @(negedge clk);
    check(busy == 1'b0, req, busy, 0);
  endtask

  task automatic measure(input logic [1:0] s, input int exp);
    int cnt;
    bsel = s;
    do_reset();
    cs_n = 1'b0; amode = 1'b0;
    @(negedge clk) begin tdata = 8'h01; load = 1'b1; end
    @(negedge clk) load = 1'b0;
    cnt = 0;
    while (txd == 1'b0 && cnt < 20000) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == exp, "R2 start bit width", cnt, exp);
  endtask

  task automatic t_reset();
    check(txd == 1'b1, "R12 txd idle", txd, 1);
    check(busy == 1'b0, "R12 busy", busy, 0);
    check(rvalid == 1'b0, "R12 strobe", rvalid, 0);
    check(perr == 1'b0, "R12 parity flag", perr, 0);
  endtask

  task automatic t_rx_basic();
    int g;
    g = n_got;
    send_frame(8'h5A, 0, 0);
    check(n_got == g + 1 && last_data == 8'h5A, "R3 byte 5A", last_data, 8'h5A);
    check(last_perr == 1'b0, "R4 good parity", last_perr, 0);
    send_frame(8'hC3, 1, 0);
    check(n_got == g + 2 && last_data == 8'hC3, "R3 byte C3", last_data, 8'hC3);
    check(perr == 1'b1, "R4 bad parity held", perr, 1);
    send_frame(8'h00, 0, 0);
    check(perr == 1'b0, "R4 parity flag cleared", perr, 0);
  endtask

  task automatic t_framing();
    int g;
    g = n_got;
    send_frame(8'h77, 0, 1);
    check(n_got == g, "R5 low stop dropped", n_got - g, 0);
  endtask

  task automatic t_glitch();
    int g;
    g = n_got;
    @(negedge clk) rxd = 1'b0;
    repeat (3 * DIVF) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BT) @(negedge clk);
    check(n_got == g, "R6 glitch ignored", n_got - g, 0);
    send_frame(8'hE1, 0, 0);
    check(n_got == g + 1 && last_data == 8'hE1, "R6 frame after glitch", last_data, 8'hE1);
  endtask

  task automatic t_cs_gate();
    int g;
    g = n_got;
    cs_n = 1'b1;
    send_frame(8'h3C, 0, 0);
    check(n_got == g, "R7 rx gated by cs", n_got - g, 0);
    @(negedge clk) begin tdata = 8'hAA; load = 1'b1; end
    @(negedge clk) load = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && txd == 1'b1, "R7 tx gated by cs", busy, 0);
    cs_n = 1'b0;
  endtask

  task automatic t_addressed();
    int g;
    amode = 1'b1; cs_n = 1'b1;
    g = n_got;
    send_frame(8'h22, 0, 0);
    check(n_got == g, "R9 unselected data dropped", n_got - g, 0);
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R9 unselected tx ignored", busy, 0);
    send_frame(8'h93, 0, 0);
    check(n_got == g, "R8 address byte hidden", n_got - g, 0);
    send_frame(8'h44, 0, 0);
    check(n_got == g + 1 && last_data == 8'h44, "R9 selected data", last_data, 8'h44);
    send_frame(8'hB3, 0, 0);
    check(n_got == g + 2 && last_data == 8'hB3, "R8 bit5 set is data", last_data, 8'hB3);
    tx_check(8'h5E, 0, "R9 selected tx");
    send_frame(8'h85, 0, 0);
    check(n_got == g + 2, "R10 foreign address hidden", n_got - g, 2);
    send_frame(8'h66, 0, 0);
    check(n_got == g + 2, "R10 deselected data dropped", n_got - g, 2);
    amode = 1'b0; cs_n = 1'b0;
  endtask

  task automatic t_overlap();
    int g;
    g = n_got;
    fork
      tx_check(8'h96, 0, "R1 tx during rx");
      send_frame(8'h69, 1, 0);
    join
    check(n_got == g + 1 && last_data == 8'h69, "R3 rx during tx", last_data, 8'h69);
    check(last_perr == 1'b1, "R4 rx during tx parity", last_perr, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    tx_check(8'hA5, 0, "R1 frame A5");
    tx_check(8'h3C, 0, "R1 frame 3C");
    tx_check(8'hC1, 1, "R11 load while busy");
    t_rx_basic();
    t_framing();
    t_glitch();
    t_cs_gate();
    t_addressed();
    t_overlap();
    measure(2'b00, 16 * 512);
    measure(2'b10, 16 * 128);
    measure(2'b01, 16 * 16);
    measure(2'b11, 16 * 8);
    do_reset();
    t_reset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule